// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits between a group of parallel lanes and a scratchpad built from independent single-ported banks of 32-bit words. The lanes present one combined request. Each lane has a valid bit, a word address, a write flag and write data. The arbiter breaks that request into passes. In any pass each bank is touched at most once. Lanes whose words fall in different banks are served in the same pass. Lanes that collide on a bank with different words are spread over later passes. Read data is collected per lane, and a single-cycle completion pulse reports the end of the request together with the number of passes used.

The bank index of a word is its low address bits. The remaining bits select the row inside that bank. Lanes that name the same word are merged into one bank access. Concurrent reads of that word are a broadcast. Concurrent writes to it resolve in favour of the highest-numbered lane. While a request is being served the block ignores the request strobe.

Control is a three-state machine:
- `ST_IDLE` accepts a request (transition *accept*: strobe seen while idle).
- `ST_ISSUE` drives one pass per cycle. It stays there while lanes remain (transition *more*) and leaves when the last pending lane is served (transition *drain*).
- `ST_DONE` raises the completion pulse for one cycle and returns to `ST_IDLE` (transition *release*).

Top module: `sp_bank_arbiter`

## Requirements
- R1: The bank of a word is address bits [3:0] and its row within the bank is address bits [AW-1:4]. A write lands in that bank and row, and a later read of the same address returns it.
- R2: When every valid lane maps to a different bank, the whole request completes in one pass.
- R3: Valid lanes that address different words of one bank are served in successive passes, one word per bank per pass, until none remain.
- R4: In each pass, each bank serves the word of the lowest-numbered lane still pending for that bank. Losing lanes remain pending.
- R5: Any number of lanes reading the same word are served in the same pass as a broadcast, with no added pass.
- R6: When several lanes write the same word, they take one pass and the stored value is the data of the highest-numbered writing lane.
- R7: `pass_count`, valid while `done` is high, equals the largest number of distinct words requested in any single bank.
- R8: While a request is in progress `req_ready` is low. A `req_valid` pulse in that time has no effect on the bank contents or the results.
- R9: `done` is high for exactly one cycle, one cycle after the last pass. At that time `lane_rdata` holds read data for valid reading lanes and zero for all other lanes. A request with no valid lane finishes with `pass_count` of zero.
- R10: A lane reading a word that another lane writes in the same request receives the contents that word had before the request.
- R11: After reset `req_ready` is 1 and `done`, `bank_en` and `pass_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_ready | output | 1 | High while idle and able to accept |
| lane_valid | input | LANES | Per-lane participation bit |
| lane_we | input | LANES | Per-lane write flag (1 = write) |
| lane_addr | input | LANES*AW | Per-lane word address, lane l at bits [l*AW +: AW] |
| lane_wdata | input | LANES*DW | Per-lane write data |
| lane_rdata | output | LANES*DW | Per-lane gathered read data |
| done | output | 1 | One-cycle completion pulse |
| pass_count | output | $clog2(LANES+1) | Passes used by the last request |
| bank_en | output | BANKS | Per-bank access enable for this pass |
| bank_we | output | BANKS | Per-bank write enable |
| bank_row | output | BANKS*(AW-4) | Per-bank row index |
| bank_wdata | output | BANKS*DW | Per-bank write data |
| bank_rdata | input | BANKS*DW | Per-bank read data, combinational from the selected row |

## Verification
The bench builds the block with its defaults: 16 lanes, 16 banks, 8-bit word addresses and 32-bit data. That gives 16 rows per bank, so all 16 lanes can pile onto one bank with distinct words, or spread across every bank in a single pass. Those defaults make the extremes of the pass count reachable: zero for an empty request, one for a full spread or broadcast, and several for deep collisions. The per-bank storage lives in the bench. This lets the order in which rows are presented in the first pass be observed directly on the bank ports.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/sp_arb_select.sv
module sp_arb_select #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic [LANES-1:0]          pending,
    input  logic [LANES-1:0]          we,
    input  logic [AW-1:0]             addr  [LANES],
    input  logic [DW-1:0]             wdata [LANES],
    output logic [LANES-1:0]          served,
    output logic [BANKS-1:0]          bank_en,
    output logic [BANKS-1:0]          bank_we,
    output logic [AW-$clog2(BANKS)-1:0] bank_row [BANKS],
    output logic [DW-1:0]             bank_wdata [BANKS]
);
    localparam int BB = $clog2(BANKS);

    logic [AW-1:0] win_addr [BANKS];

    always_comb begin
        bank_en = '0;
        bank_we = '0;
        served  = '0;
        for (int b = 0; b < BANKS; b++) begin
            win_addr[b]   = '0;
            bank_wdata[b] = '0;
        end
        // lowest pending lane claims each bank
        for (int b = 0; b < BANKS; b++) begin
            for (int l = 0; l < LANES; l++) begin
                if (pending[l] && (addr[l][BB-1:0] == BB'(b)) && !bank_en[b]) begin
                    bank_en[b]  = 1'b1;
                    win_addr[b] = addr[l];
                end
            end
        end
        // every pending lane naming the claimed word rides along
        for (int l = 0; l < LANES; l++) begin
            served[l] = pending[l] && bank_en[addr[l][BB-1:0]]
                        && (addr[l] == win_addr[addr[l][BB-1:0]]);
        end
        // writers merge; ascending scan leaves the highest lane last
        for (int b = 0; b < BANKS; b++) begin
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && we[l] && (addr[l][BB-1:0] == BB'(b))) begin
                    bank_we[b]    = 1'b1;
                    bank_wdata[b] = wdata[l];
                end
            end
        end
        for (int b = 0; b < BANKS; b++) begin
            bank_row[b] = win_addr[b][AW-1:BB];
        end
    end
endmodule

// File: rtl/sp_arb_ctrl.sv
module sp_arb_ctrl
    import sp_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic lanes_left,
    output logic ready,
    output logic accept,
    output logic issuing,
    output logic done
);
    arb_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid)   nxt = ST_ISSUE;
            ST_ISSUE: if (!lanes_left) nxt = ST_DONE;
            ST_DONE:                   nxt = ST_IDLE;
            default:                   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ready   = (state == ST_IDLE);
        accept  = (state == ST_IDLE) && req_valid;
        issuing = (state == ST_ISSUE);
        done    = (state == ST_DONE);
    end
endmodule

// File: rtl/sp_bank_arbiter.sv
module sp_bank_arbiter #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int BB    = $clog2(BANKS),
    localparam int ROW_W = AW - BB,
    localparam int PCW   = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [LANES-1:0]       lane_valid,
    input  logic [LANES-1:0]       lane_we,
    input  logic [LANES*AW-1:0]    lane_addr,
    input  logic [LANES*DW-1:0]    lane_wdata,
    output logic [LANES*DW-1:0]    lane_rdata,
    output logic                   done,
    output logic [PCW-1:0]         pass_count,
    output logic [BANKS-1:0]       bank_en,
    output logic [BANKS-1:0]       bank_we,
    output logic [BANKS*ROW_W-1:0] bank_row,
    output logic [BANKS*DW-1:0]    bank_wdata,
    input  logic [BANKS*DW-1:0]    bank_rdata
);
    logic [LANES-1:0] pend_q, we_q, served;
    logic [AW-1:0]    addr_q  [LANES];
    logic [DW-1:0]    wd_q    [LANES];
    logic [DW-1:0]    rd_q    [LANES];
    logic [ROW_W-1:0] row_w   [BANKS];
    logic [DW-1:0]    bwd_w   [BANKS];
    logic [DW-1:0]    brd_w   [BANKS];
    logic [PCW-1:0]   pass_q;
    logic             accept, issuing, lanes_left;

    assign lanes_left = |(pend_q & ~served);

    sp_arb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lanes_left (lanes_left),
        .ready      (req_ready),
        .accept     (accept),
        .issuing    (issuing),
        .done       (done)
    );

    sp_arb_select #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)) u_sel (
        .pending    (pend_q & {LANES{issuing}}),
        .we         (we_q),
        .addr       (addr_q),
        .wdata      (wd_q),
        .served     (served),
        .bank_en    (bank_en),
        .bank_we    (bank_we),
        .bank_row   (row_w),
        .bank_wdata (bwd_w)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_row[b*ROW_W +: ROW_W] = row_w[b];
        assign bank_wdata[b*DW +: DW]     = bwd_w[b];
        assign brd_w[b]                   = bank_rdata[b*DW +: DW];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_rdata[l*DW +: DW] = rd_q[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            we_q   <= '0;
            pass_q <= '0;
            for (int l = 0; l < LANES; l++) begin
                addr_q[l] <= '0;
                wd_q[l]   <= '0;
                rd_q[l]   <= '0;
            end
        end else if (accept) begin
            pend_q <= lane_valid;
            we_q   <= lane_we;
            pass_q <= '0;
            for (int l = 0; l < LANES; l++) begin
                addr_q[l] <= lane_addr[l*AW +: AW];
                wd_q[l]   <= lane_wdata[l*DW +: DW];
                rd_q[l]   <= '0;
            end
        end else if (issuing) begin
            pend_q <= pend_q & ~served;
            if (|served) pass_q <= pass_q + PCW'(1);
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && !we_q[l]) rd_q[l] <= brd_w[addr_q[l][BB-1:0]];
            end
        end
    end

    assign pass_count = pass_q;
endmodule

// File: rtl/sp_arb_checker.sv
module sp_arb_checker #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int PCW   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             done,
    input logic [BANKS-1:0] bank_en,
    input logic [PCW-1:0]   pass_count,
    input logic [LANES-1:0] pend_q,
    input logic [LANES-1:0] served
);
    // R8: banks stay untouched while idle
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bank_en == '0));

    // R9: completion lasts one cycle and returns to idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R3: every busy pass retires at least one pending lane
    p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !done && (pend_q != '0)) |-> (served != '0));

    // R4: only pending lanes are served
    p_served_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (served & ~pend_q) == '0);

    // R7: pass count never exceeds the lane count
    p_pass_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass_count <= PCW'(LANES)));
endmodule

bind sp_bank_arbiter sp_arb_checker #(.LANES(LANES), .BANKS(BANKS), .PCW(PCW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .done       (done),
    .bank_en    (bank_en),
    .pass_count (pass_count),
    .pend_q     (pend_q),
    .served     (served)
);

// File: tb/tb_sp_bank_arbiter.sv
`timescale 1ns/1ps
module tb_sp_bank_arbiter;
    localparam int LANES = 16, BANKS = 16, AW = 8, DW = 32;
    localparam int BB = 4, ROW_W = AW - BB, ROWS = 1 << ROW_W, PCW = 5;

    logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
    logic req_ready, done;
    logic [LANES-1:0] lane_valid = '0, lane_we = '0;
    logic [LANES*AW-1:0] lane_addr = '0;
    logic [LANES*DW-1:0] lane_wdata = '0, lane_rdata;
    logic [PCW-1:0] pass_count;
    logic [BANKS-1:0] bank_en, bank_we;
    logic [BANKS*ROW_W-1:0] bank_row;
    logic [BANKS*DW-1:0] bank_wdata, bank_rdata;

    always #2.5 clk = ~clk;

    sp_bank_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .lane_valid(lane_valid), .lane_we(lane_we), .lane_addr(lane_addr),
        .lane_wdata(lane_wdata), .lane_rdata(lane_rdata), .done(done),
        .pass_count(pass_count), .bank_en(bank_en), .bank_we(bank_we),
        .bank_row(bank_row), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    // bank storage harness
    logic [DW-1:0] mem [BANKS][ROWS];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BANKS; b++)
                for (int r = 0; r < ROWS; r++)
                    mem[b][r] <= 32'hA000_0000 | (b << 8) | r;
        end else begin
            for (int b = 0; b < BANKS; b++)
                if (bank_en[b] && bank_we[b])
                    mem[b][bank_row[b*ROW_W +: ROW_W]] <= bank_wdata[b*DW +: DW];
        end
    end
    for (genvar b = 0; b < BANKS; b++) begin : g_rd
        assign bank_rdata[b*DW +: DW] = mem[b][bank_row[b*ROW_W +: ROW_W]];
    end

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic          v [LANES];
    logic          w [LANES];
    logic [AW-1:0] a [LANES];
    logic [DW-1:0] d [LANES];
    logic [ROW_W-1:0] first_row [BANKS];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_lanes();
        for (int l = 0; l < LANES; l++) begin
            v[l] = 0; w[l] = 0; a[l] = '0; d[l] = '0;
        end
    endtask

    task automatic run_req(string tag, bit inject);
        logic [DW-1:0] exp_mem [BANKS][ROWS];
        logic [DW-1:0] exp_rd [LANES];
        int cnt [BANKS];
        int exp_pass, cyc, bad_mem, bad_zero;
        bit seen [BANKS];
        for (int b = 0; b < BANKS; b++) begin
            cnt[b] = 0; seen[b] = 0; first_row[b] = '0;
            for (int r = 0; r < ROWS; r++) exp_mem[b][r] = mem[b][r];
        end
        exp_pass = 0;
        for (int l = 0; l < LANES; l++) begin
            bit dup = 0;
            exp_rd[l] = (v[l] && !w[l]) ? mem[a[l][BB-1:0]][a[l][AW-1:BB]] : '0;
            for (int k = 0; k < l; k++) if (v[k] && a[k] == a[l]) dup = 1;
            if (v[l] && !dup) begin
                cnt[a[l][BB-1:0]]++;
                if (cnt[a[l][BB-1:0]] > exp_pass) exp_pass = cnt[a[l][BB-1:0]];
            end
            if (v[l] && w[l]) exp_mem[a[l][BB-1:0]][a[l][AW-1:BB]] = d[l];
        end
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            lane_valid[l] = v[l]; lane_we[l] = w[l];
            lane_addr[l*AW +: AW] = a[l]; lane_wdata[l*DW +: DW] = d[l];
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = inject;
        if (inject) begin
            lane_valid = '1; lane_we = '1; lane_wdata = {LANES{32'hDEAD_BEEF}};
        end
        cyc = 0;
        while (!done && cyc < 200) begin
            if (inject) check("R8 ready low while busy", {31'd0, req_ready}, 32'd0);
            for (int b = 0; b < BANKS; b++)
                if (bank_en[b] && !seen[b]) begin
                    seen[b] = 1; first_row[b] = bank_row[b*ROW_W +: ROW_W];
                end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check({"R9 done seen ", tag}, {31'd0, done}, 32'd1);
        check({"R7 pass count ", tag}, 32'(pass_count), 32'(exp_pass));
        bad_zero = 0;
        for (int l = 0; l < LANES; l++) begin
            if (v[l] && !w[l]) check({"R10 rdata ", tag}, lane_rdata[l*DW +: DW], exp_rd[l]);
            else if (lane_rdata[l*DW +: DW] != '0) bad_zero++;
        end
        check({"R9 unread lanes zero ", tag}, 32'(bad_zero), 32'd0);
        @(negedge clk);
        check({"R9 done single cycle ", tag}, {31'd0, done}, 32'd0);
        bad_mem = 0;
        for (int b = 0; b < BANKS; b++)
            for (int r = 0; r < ROWS; r++)
                if (mem[b][r] !== exp_mem[b][r]) bad_mem++;
        check({"R1 bank contents ", tag}, 32'(bad_mem), 32'd0);
    endtask

    task automatic t_reset();
        check("R11 ready", {31'd0, req_ready}, 32'd1);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 bank_en", 32'(bank_en), 32'd0);
        check("R11 pass_count", 32'(pass_count), 32'd0);
    endtask

    task automatic t_spread();
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin
            v[l] = 1; w[l] = 1; a[l] = AW'(((l ^ 3) << 4) | (15 - l)); d[l] = 32'h5000 + l;
        end
        run_req("R2 spread write", 0);
        check("R2 one pass", 32'(pass_count), 32'd1);
        for (int l = 0; l < LANES; l++) w[l] = 0;
        run_req("R1 readback", 0);
        for (int l = 0; l < LANES; l++)
            check("R1 readback value", lane_rdata[l*DW +: DW], 32'h5000 + l);
    endtask

    task automatic t_conflict();
        clear_lanes();
        for (int l = 0; l < 4; l++) begin v[l] = 1; a[l] = AW'((l << 4) | 5); end
        v[4] = 1; a[4] = 8'h19; v[5] = 1; a[5] = 8'h29;
        run_req("R3 four-deep", 0);
        check("R3 passes", 32'(pass_count), 32'd4);
    endtask

    task automatic t_order();
        clear_lanes();
        v[0] = 1; a[0] = 8'h53; v[1] = 1; a[1] = 8'h93; v[2] = 1; a[2] = 8'h53;
        v[3] = 1; a[3] = 8'hE7; v[4] = 1; a[4] = 8'h27;
        run_req("R4 order", 0);
        check("R4 first row bank3", 32'(first_row[3]), 32'd5);
        check("R4 first row bank7", 32'(first_row[7]), 32'd14);
    endtask

    task automatic t_bcast();
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin v[l] = 1; a[l] = 8'h42; end
        run_req("R5 broadcast", 0);
        check("R5 one pass", 32'(pass_count), 32'd1);
        check("R5 lane15 data", lane_rdata[15*DW +: DW], 32'hA000_0204);
    endtask

    task automatic t_wmerge();
        clear_lanes();
        for (int l = 0; l < LANES; l++) begin v[l] = 1; w[l] = 1; a[l] = 8'h77; d[l] = 32'h1000 + l; end
        w[14] = 0;
        d[15] = 32'hBEEF;
        run_req("R6 merge", 0);
        check("R6 one pass", 32'(pass_count), 32'd1);
        check("R6 highest writer", mem[7][7], 32'hBEEF);
        check("R10 reader sees old", lane_rdata[14*DW +: DW], 32'hA000_0707);
    endtask

    task automatic t_busy();
        clear_lanes();
        for (int l = 0; l < 3; l++) begin v[l] = 1; w[l] = 1; a[l] = AW'((l << 4) | 2); d[l] = 32'h7700 + l; end
        run_req("R8 busy", 1);
        check("R8 passes", 32'(pass_count), 32'd3);
    endtask

    task automatic t_empty();
        clear_lanes();
        run_req("R9 empty", 0);
        check("R9 zero passes", 32'(pass_count), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_spread();
        t_conflict();
        t_order();
        t_bcast();
        t_wmerge();
        t_busy();
        t_empty();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule